// File: doc/BRIEF.md
# Card Clock Update Handshake Unit

This block generates the card clock of an SD/MMC host from the system clock. Software programs the wanted setting into a clock configuration register: a divider field, a run-enable bit and an idle-gating bit. That write only fills a shadow copy. The card clock does not change until software issues a clock-update request through the command register, with the start bit set. No card command goes out on the bus for such a request.

The block loads the shadow copy into the live setting at a safe point, where the divided clock is low. It can also wait for the data path to go idle first. It then clears the start bit, which software polls to see that the update is finished, and sets only the command-done bit of the raw interrupt status. The live setting stops, gates or divides the card clock. A divider of zero passes the source clock straight through, gated by a clock-low latch.

Top module: `sdclk_update_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the clock configuration readback, the start bit and the raw status are all zero, and the card clock is held low.
- R2: A configuration write (select 0) stores the divider from data bits 7:0, the run-enable from bit 16 and the idle-gating from bit 17. All other readback bits are zero. The write alone does not change the card clock.
- R3: A command write (select 1) with bit 31 and bit 21 both set raises the start readback from the next cycle. The start readback clears once the shadow setting has been loaded. A command write missing either bit leaves the start readback at zero and the card clock unchanged.
- R4: When the request also has bit 13 set, the load waits while data_busy is high and happens within a few cycles after data_busy falls. Without bit 13, the load does not wait for data_busy.
- R5: With run-enable clear in the live setting, the card clock stays low.
- R6: A divider value N greater than zero gives a card clock that is high for N source cycles and low for N source cycles.
- R7: A divider value of zero with run-enable set makes the card clock follow the source clock: high while the source is high, low while it is low.
- R8: The live setting changes only while the divided clock is low. A divider change on a running clock therefore produces no high or low phase shorter than the smaller of the old and new N.
- R9: With idle-gating set, the card clock stops while both cmd_active and data_busy are low. It runs at the programmed rate while either of them is high.
- R10: Each completed load sets raw status bit 2 and no other bit. A write to select 2 clears the raw status bits that are one in its data bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 clock configuration, 1 command, 2 raw-status clear |
| reg_wdata | input | 32 | Write data |
| data_busy | input | 1 | Data path busy with a transfer |
| cmd_active | input | 1 | Command path busy |
| clkcfg_rdata | output | 32 | Readback of the shadow clock configuration |
| cmd_start | output | 1 | Start bit readback, high while an update is pending |
| raw_int | output | 16 | Raw interrupt status |
| card_clk | output | 1 | Card clock |

## Verification
The embedded properties check on every cycle that:
- a divided high phase lasts exactly the programmed N;
- the live setting moves only from a low phase;
- the clock stays low while stopped;
- the bypass path and the divider are never active together;
- the start bit drops after a load;
- a load with the wait bit set is held off by data_busy;
- the done bit rises only on a load.

Only the bench scenarios show the things the properties cannot see:
- the register readback masking;
- that malformed commands are ignored;
- the exact high and low run lengths for several divider values;
- the phase of the bypass clock against the source;
- idle gating that follows cmd_active;
- the write-one-to-clear behaviour of the status bits.

// File: rtl/sdclk_pkg.sv
// sdclk_pkg: shared widths, bit positions and types of the card clock
// update unit. Assumes a 32-bit register write bus.
package sdclk_pkg;
    localparam int DIV_W    = 8;   // divider field width
    localparam int REG_W    = 32;  // register data width
    localparam int RAW_W    = 16;  // raw status width
    localparam int ON_BIT   = 16;  // run-enable position in configuration word
    localparam int LP_BIT   = 17;  // idle-gating position in configuration word
    localparam int GO_BIT   = 31;  // command start bit
    localparam int UPD_BIT  = 21;  // command "update clock only" bit
    localparam int WAIT_BIT = 13;  // command "wait for data idle" bit
    localparam int DONE_BIT = 2;   // raw status command-done bit

    typedef enum logic [1:0] {
        SEL_CLKCFG = 2'd0,
        SEL_CMD    = 2'd1,
        SEL_RAWCLR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             lowpwr;
        logic             on;
        logic [DIV_W-1:0] div;
    } clk_cfg_t;
endpackage

// File: rtl/sdclk_cfg_regs.sv
// sdclk_cfg_regs: shadow and live clock configuration, the start-bit
// handshake and the raw status. Assumes div_high is the registered divided
// clock; a load is only allowed while it is low.
module sdclk_cfg_regs
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             data_busy,
    input  logic             div_high,
    output clk_cfg_t         shadow_o,
    output clk_cfg_t         active_o,
    output logic             apply_o,
    output logic             start_o,
    output logic [RAW_W-1:0] raw_o
);
    localparam logic [RAW_W-1:0] DONE_MASK = RAW_W'(1) << DONE_BIT;

    clk_cfg_t         shadow_q, active_q;
    logic             pend_q, wait_q;
    logic [RAW_W-1:0] raw_q;
    logic             wr_cfg, wr_cmd, wr_clr, upd_req, apply;
    logic             unused_wdata;

    assign wr_cfg  = reg_wr && (reg_sel == SEL_CLKCFG);
    assign wr_cmd  = reg_wr && (reg_sel == SEL_CMD);
    assign wr_clr  = reg_wr && (reg_sel == SEL_RAWCLR);
    assign upd_req = wr_cmd && reg_wdata[GO_BIT] && reg_wdata[UPD_BIT] && !pend_q;
    // load point: request pending, data path allowed, divided clock low
    assign apply   = pend_q && (!wait_q || !data_busy) && !div_high;
    assign unused_wdata = &{1'b0, reg_wdata};

    // shadow capture, live load, handshake and raw status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
            pend_q   <= 1'b0;
            wait_q   <= 1'b0;
            raw_q    <= '0;
        end else begin
            if (wr_cfg) begin
                shadow_q.div    <= reg_wdata[DIV_W-1:0];
                shadow_q.on     <= reg_wdata[ON_BIT];
                shadow_q.lowpwr <= reg_wdata[LP_BIT];
            end
            if (apply) begin
                active_q <= shadow_q;
                pend_q   <= 1'b0;
            end else if (upd_req) begin
                pend_q <= 1'b1;
                wait_q <= reg_wdata[WAIT_BIT];
            end
            raw_q <= (raw_q & ~(wr_clr ? reg_wdata[RAW_W-1:0] : '0))
                   | (apply ? DONE_MASK : '0);
        end
    end

    assign shadow_o = shadow_q;
    assign active_o = active_q;
    assign apply_o  = apply;
    assign start_o  = pend_q;
    assign raw_o    = raw_q;

    // R3: start readback drops right after a load
    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> !pend_q);
    // R4: a waiting request is held while the data path is busy
    p_wait_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && wait_q && data_busy) |=> pend_q);
    // R10: the done bit only rises as a pending request completes
    p_done_from_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q[DONE_BIT]) |-> ($past(pend_q) && !pend_q));
endmodule

// File: rtl/sdclk_gate_cell.sv
// sdclk_gate_cell: clock gate with a latch that is open while the clock is
// low, so the enable can only change the output between pulses.
module sdclk_gate_cell (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    // hold the enable through the high phase
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/sdclk_divgen.sv
// sdclk_divgen: divides the source clock by 2N, or bypasses it when N is 0.
// Assumes cfg_i changes only on apply_i, which comes while div_q is low.
// A stop request lets a running high phase finish first.
module sdclk_divgen
    import sdclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  clk_cfg_t cfg_i,
    input  logic     apply_i,
    input  logic     cmd_active,
    input  logic     data_busy,
    output logic     div_q_o,
    output logic     card_clk_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic             div_q, run, bypass, gclk;
    logic [DIV_W:0]   hi_len;

    assign run    = cfg_i.on && !(cfg_i.lowpwr && !cmd_active && !data_busy);
    assign bypass = (cfg_i.div == '0);

    // half-period counter and divided clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (apply_i) begin
            cnt_q <= '0;
        end else if ((run || div_q) && !bypass) begin
            if (cnt_q == cfg_i.div - ONE) begin
                cnt_q <= '0;
                div_q <= ~div_q;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    sdclk_gate_cell u_gate (
        .clk_i  (clk),
        .en_i   (run && bypass),
        .gclk_o (gclk)
    );

    assign div_q_o    = div_q;
    assign card_clk_o = div_q | gclk;

    // checker state: length of the current high phase
    always_ff @(posedge clk) begin
        if (!rst_n || !div_q) hi_len <= '0;
        else                  hi_len <= hi_len + 1'b1;
    end

    // R6: every high phase lasts exactly N source cycles
    p_high_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_q) |-> (hi_len == {1'b0, cfg_i.div}));
    // R8: the live setting moves only out of a low phase
    p_load_when_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_i) |-> !$past(div_q));
    // R5: a stopped clock stays low
    p_stopped_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !div_q) |=> !div_q);
    // R7: bypass path and divider never drive together
    p_bypass_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bypass) |-> !div_q);
endmodule

// File: rtl/sdclk_update_ctrl.sv
// sdclk_update_ctrl: card clock generator whose settings take effect only
// through an update-clock command with a self-clearing start bit.
// Assumes single-cycle register write strobes on the source clock.
module sdclk_update_ctrl
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             data_busy,
    input  logic             cmd_active,
    output logic [REG_W-1:0] clkcfg_rdata,
    output logic             cmd_start,
    output logic [RAW_W-1:0] raw_int,
    output logic             card_clk
);
    clk_cfg_t shadow, active;
    logic     apply, div_high;

    sdclk_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .data_busy (data_busy),
        .div_high  (div_high),
        .shadow_o  (shadow),
        .active_o  (active),
        .apply_o   (apply),
        .start_o   (cmd_start),
        .raw_o     (raw_int)
    );

    sdclk_divgen u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (active),
        .apply_i    (apply),
        .cmd_active (cmd_active),
        .data_busy  (data_busy),
        .div_q_o    (div_high),
        .card_clk_o (card_clk)
    );

    // readback of the shadow configuration, unused bits zero
    always_comb begin
        clkcfg_rdata              = '0;
        clkcfg_rdata[DIV_W-1:0]   = shadow.div;
        clkcfg_rdata[ON_BIT]      = shadow.on;
        clkcfg_rdata[LP_BIT]      = shadow.lowpwr;
    end
endmodule

// File: tb/tb_sdclk_update_ctrl.sv
`timescale 1ns/100ps
module tb_sdclk_update_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic        data_busy = 1'b0;
    logic        cmd_active = 1'b0;
    logic [31:0] clkcfg_rdata;
    logic        cmd_start;
    logic [15:0] raw_int;
    logic        card_clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [31:0] CMD_UPD_WAIT = 32'h8020_2000;
    localparam logic [31:0] CMD_UPD_NOW  = 32'h8020_0000;
    // table: bit 8 run-enable, bits 7:0 divider
    localparam logic [8:0] VEC [4] = '{9'h101, 9'h103, 9'h106, 9'h004};

    always #2.5 clk = ~clk;

    sdclk_update_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .data_busy(data_busy), .cmd_active(cmd_active),
        .clkcfg_rdata(clkcfg_rdata), .cmd_start(cmd_start), .raw_int(raw_int),
        .card_clk(card_clk)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
    endtask

    task automatic cfg(input int div, input bit on, input bit lp);
        wr(2'd0, (32'(lp) << 17) | (32'(on) << 16) | 32'(div));
    endtask

    task automatic wait_clear(input int maxc, output bit ok);
        ok = 0;
        for (int i = 0; i <= maxc; i++) begin
            if (cmd_start == 1'b0) begin ok = 1; break; end
            @(posedge clk); #1;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        int g;
        hi = 0; lo = 0; g = 0;
        @(posedge clk); #1;
        while (card_clk !== 1'b0 && g < 2000) begin @(posedge clk); #1; g++; end
        while (card_clk !== 1'b1 && g < 2000) begin @(posedge clk); #1; g++; end
        while (card_clk === 1'b1 && g < 2000) begin hi++; @(posedge clk); #1; g++; end
        while (card_clk === 1'b0 && g < 2000) begin lo++; @(posedge clk); #1; g++; end
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; if (card_clk !== 1'b0) highs++;
            @(negedge clk); #1; if (card_clk !== 1'b0) highs++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
        finish_run();
    end

    initial begin
        bit ok;
        int hi, lo, highs;
        logic s [80];
        int cur, mn;
        bit first;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(clkcfg_rdata == 32'h0, "R1", "cfg readback", clkcfg_rdata, 0);
        chk(cmd_start == 1'b0, "R1", "start", cmd_start, 0);
        chk(raw_int == 16'h0, "R1", "raw status", raw_int, 0);
        count_high(10, highs);
        chk(highs == 0, "R1", "card clock high samples", highs, 0);

        // R2 readback masking, no effect without update
        wr(2'd0, 32'hFFFF_FFFF);
        chk(clkcfg_rdata == 32'h0003_00FF, "R2", "masked readback", clkcfg_rdata, 32'h0003_00FF);
        count_high(20, highs);
        chk(highs == 0, "R2", "clock unchanged after write", highs, 0);

        // R3 malformed commands ignored
        wr(2'd1, 32'h8000_2000);
        chk(cmd_start == 1'b0, "R3", "start without update bit", cmd_start, 0);
        wr(2'd1, 32'h0020_2000);
        chk(cmd_start == 1'b0, "R3", "update bit without start", cmd_start, 0);
        count_high(10, highs);
        chk(highs == 0 && raw_int == 16'h0, "R3", "no load from malformed cmd", highs, 0);

        // table walk: R3 handshake, R6 divider, R5 stop, R10 done bit
        for (int v = 0; v < 4; v++) begin
            cfg(int'(VEC[v][7:0]), VEC[v][8], 1'b0);
            wr(2'd1, CMD_UPD_WAIT);
            chk(cmd_start == 1'b1, "R3", "start visible after request", cmd_start, 1);
            wait_clear(40, ok);
            chk(ok, "R3", "start cleared by load", cmd_start, 0);
            chk(raw_int == 16'h0004, "R10", "only done bit set", raw_int, 4);
            wr(2'd2, 32'h0000_FFFF);
            chk(raw_int == 16'h0, "R10", "done bit cleared", raw_int, 0);
            if (VEC[v][8]) begin
                measure(hi, lo);
                chk(hi == int'(VEC[v][7:0]), "R6", "high length", hi, int'(VEC[v][7:0]));
                chk(lo == int'(VEC[v][7:0]), "R6", "low length", lo, int'(VEC[v][7:0]));
            end else begin
                count_high(20, highs);
                chk(highs == 0, "R5", "disabled clock stays low", highs, 0);
            end
        end

        // R8 divider change while running: 3 -> 5
        cfg(3, 1'b1, 1'b0);
        wr(2'd1, CMD_UPD_NOW);
        wait_clear(20, ok);
        repeat (10) @(posedge clk);
        cfg(5, 1'b1, 1'b0);
        wr(2'd1, CMD_UPD_NOW);
        for (int i = 0; i < 80; i++) begin @(posedge clk); #1; s[i] = card_clk; end
        cur = 1; mn = 1000; first = 1;
        for (int i = 1; i < 80; i++) begin
            if (s[i] == s[i-1]) cur++;
            else begin
                if (!first && cur < mn) mn = cur;
                first = 0; cur = 1;
            end
        end
        chk(mn >= 3, "R8", "shortest phase across change", mn, 3);
        measure(hi, lo);
        chk(hi == 5 && lo == 5, "R8", "new divider in force", hi, 5);
        wr(2'd2, 32'h0000_FFFF);

        // R7 bypass
        cfg(0, 1'b1, 1'b0);
        wr(2'd1, CMD_UPD_NOW);
        wait_clear(20, ok);
        repeat (2) @(posedge clk);
        hi = 0; lo = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1; if (card_clk === 1'b1) hi++;
            @(negedge clk); #1; if (card_clk === 1'b0) lo++;
        end
        chk(hi == 8 && lo == 8, "R7", "follows source clock", hi + lo, 16);
        wr(2'd2, 32'h0000_FFFF);

        // R4 wait for data idle
        data_busy = 1'b1;
        cfg(2, 1'b1, 1'b0);
        wr(2'd1, CMD_UPD_WAIT);
        repeat (10) @(posedge clk);
        #1;
        chk(cmd_start == 1'b1 && raw_int == 16'h0, "R4", "held while busy", cmd_start, 1);
        data_busy = 1'b0;
        wait_clear(6, ok);
        chk(ok, "R4", "loads after busy falls", cmd_start, 0);
        wr(2'd2, 32'h0000_FFFF);
        data_busy = 1'b1;
        cfg(4, 1'b1, 1'b0);
        wr(2'd1, CMD_UPD_NOW);
        wait_clear(12, ok);
        chk(ok, "R4", "no wait bit ignores busy", cmd_start, 0);
        data_busy = 1'b0;
        wr(2'd2, 32'h0000_FFFF);

        // R9 idle gating
        cfg(2, 1'b1, 1'b1);
        wr(2'd1, CMD_UPD_WAIT);
        wait_clear(20, ok);
        repeat (6) @(posedge clk);
        count_high(20, highs);
        chk(highs == 0, "R9", "stopped while idle", highs, 0);
        #1 cmd_active = 1'b1;
        measure(hi, lo);
        chk(hi == 2 && lo == 2, "R9", "runs while command active", hi, 2);
        #1 cmd_active = 1'b0;
        repeat (6) @(posedge clk);
        count_high(20, highs);
        chk(highs == 0, "R9", "stops again when idle", highs, 0);

        // R10 write-one-to-clear selectivity
        chk(raw_int == 16'h0004, "R10", "done bit after gated load", raw_int, 4);
        wr(2'd2, 32'h0000_FFFB);
        chk(raw_int == 16'h0004, "R10", "clear of other bits leaves done", raw_int, 4);
        wr(2'd2, 32'h0000_0004);
        chk(raw_int == 16'h0, "R10", "done bit cleared", raw_int, 0);

        finish_run();
    end
endmodule